// File: doc/BRIEF.md
# Serial Register Line Sequencer

This block produces the horizontal timing for reading one line out of an area image sensor that has a masked storage zone and a bidirectional serial output register. A request on `line_start` first holds every register clock low for a quiet interval. It then raises the storage-to-register transfer gate for a fixed time and holds a second quiet interval. After that it shifts the line out element by element. Each element gets one full cycle of the complementary two-phase register clock, a reset-gate pulse at its start and a sample strobe a little later. Along with these, the block reports a tag that classifies the element currently being shifted.

The six register electrodes are driven from the two clock phases. The wiring of phases to electrodes depends on the port mode: single output on the first amplifier, mirrored single output on the second amplifier, or both amplifiers in parallel. In the parallel mode each amplifier receives only half of the useful pixels, so the line has fewer elements. When binning is enabled, the reset gate and strobe fire only on every second element, so that two neighbouring pixels sum on the sense node. The mode and the binning choice are captured when a line is accepted and hold until the line ends.

Top module: `ccdl_line_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a line is accepted, `busy`, `xfer_gate`, `reset_gate`, `sample_stb` and all six `reg_el` bits are 0, and `elem_tag` is 0 (no element).
- R2: A `line_start` seen while idle is followed by GAP_CYC cycles (default 5) with `busy` high and every output low. Then `xfer_gate` is high for exactly XFER_CYC cycles (default 8). Then GAP_CYC more cycles pass with all register clocks low before the first element begins.
- R3: A line holds these elements in order: 12 prescan (tag 1), 1 isolation (tag 2), 16 dark reference (tag 3), 5 isolation (tag 2), then the useful pixels (tag 4). There are 1024 useful pixels in modes 0, 1 and 3, which makes 1058 elements. Mode 2 has 512 useful pixels, which makes 546 elements. Tag 0 means no element.
- R4: Each element lasts ELEM_CYC cycles (default 4). Phase L1 is high for the first half and phase L2 for the second half. The two phases are never high together, and both are low outside the shifting interval.
- R5: Mode 0 (single port, first output), and mode 3, which behaves the same: `reg_el` bits 0, 2 and 4 follow L1, and bits 1, 3 and 5 follow L2. Bit i drives electrode i+1.
- R6: Mode 1 (mirrored single port, second output): bits 0, 3 and 5 follow L1, and bits 1, 2 and 4 follow L2.
- R7: Mode 2 (dual port): bits 0, 2 and 5 follow L1, and bits 1, 3 and 4 follow L2.
- R8: Without binning, `reset_gate` is high in the first cycle of every element. `sample_stb` is high in the third cycle of that element, one cycle after the reset gate has gone low.
- R9: With binning, the reset pulse and strobe occur only on elements with even index (the first element is index 0). A 1058-element line then gives 529 of each, and a 546-element line gives 273.
- R10: `line_start`, `port_mode` and `bin_en` have no effect while `busy` is high. The running line keeps the mode and binning captured at its start, and no second transfer gate follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Request one line readout (taken only when idle) |
| port_mode | input | 2 | 0 first output, 1 mirrored second output, 2 dual port, 3 as 0 |
| bin_en | input | 1 | Enable reset on every second element |
| xfer_gate | output | 1 | Storage-to-register transfer gate |
| reg_el | output | 6 | Drives for register electrodes 1..6 (bit 0 = electrode 1) |
| reset_gate | output | 1 | Output-node reset pulse |
| sample_stb | output | 1 | Strobe for the downstream sampler |
| elem_tag | output | 3 | Class of the current element (0 none, 1 prescan, 2 isolation, 3 dark, 4 pixel) |
| busy | output | 1 | A line is in progress |

## Verification
Several internal faults show up at the ports within one element period. A wrong phase counter skews the L1/L2 duty or pushes the strobe away from its reset. A wrong mode latch or routing table gives a wrong electrode pattern at the next phase edge. An error in the element counter or the class boundaries is slower to show: it first appears as a wrong tag at the boundary it disturbs, and as a wrong element count or a late drop of `busy` at the end of the line. A wrong gap or transfer counter changes the length of the idle and gate intervals before the first clock edge of the line.

// File: rtl/ccdl_pkg.sv
// Shared types for the serial register line sequencer.
// Assumes: six register electrodes, fixed phase-to-electrode wiring per mode.
package ccdl_pkg;

    localparam int EL_N = 6;

    localparam logic [1:0] MODE_OUT1   = 2'd0;
    localparam logic [1:0] MODE_MIRROR = 2'd1;
    localparam logic [1:0] MODE_DUAL   = 2'd2;

    typedef enum logic [2:0] {
        TAG_NONE    = 3'd0,
        TAG_PRESCAN = 3'd1,
        TAG_ISOL    = 3'd2,
        TAG_DARK    = 3'd3,
        TAG_PIXEL   = 3'd4
    } tag_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_XFER  = 3'd2,
        ST_TRAIL = 3'd3,
        ST_SHIFT = 3'd4
    } seq_st_t;

    // Electrodes driven by phase L1 for a mode; the rest take phase L2.
    function automatic logic [EL_N-1:0] l1_map(input logic [1:0] m);
        case (m)
            MODE_MIRROR: l1_map = 6'b101001;
            MODE_DUAL:   l1_map = 6'b100101;
            default:     l1_map = 6'b010101;
        endcase
    endfunction

endpackage

// File: rtl/ccdl_line_ctrl.sv
// Line control: accepts a request when idle, walks the quiet/transfer/quiet
// sequence, then counts elements and sub-cycles and classifies each element.
// Assumes GAP_CYC >= 1, XFER_CYC >= 1, ELEM_CYC >= 4, PIX even.
module ccdl_line_ctrl
    import ccdl_pkg::*;
#(
    parameter int GAP_CYC  = 5,
    parameter int XFER_CYC = 8,
    parameter int ELEM_CYC = 4,
    parameter int PRE      = 12,
    parameter int ISO_A    = 1,
    parameter int DARK     = 16,
    parameter int ISO_B    = 5,
    parameter int PIX      = 1024
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  mode_in,
    input  logic                        bin_in,
    output logic                        shifting,
    output logic                        xfer,
    output logic                        busy,
    output logic [$clog2(ELEM_CYC)-1:0] sub,
    output logic                        elem_odd,
    output logic [1:0]                  mode_q,
    output logic                        bin_q,
    output tag_t                        tag
);
    localparam int HEAD     = PRE + ISO_A + DARK + ISO_B;
    localparam int NEL_FULL = HEAD + PIX;
    localparam int NEL_HALF = HEAD + PIX / 2;
    localparam int EW       = $clog2(NEL_FULL + 1);
    localparam int CMAX     = (GAP_CYC > XFER_CYC) ? GAP_CYC : XFER_CYC;
    localparam int CW       = $clog2(CMAX + 1);
    localparam int SW       = $clog2(ELEM_CYC);

    seq_st_t         st;
    logic [CW-1:0]   cnt;
    logic [EW-1:0]   elem;
    logic [EW-1:0]   last_idx;

    // Last element index for the captured port mode.
    assign last_idx = (mode_q == MODE_DUAL) ? EW'(NEL_HALF - 1) : EW'(NEL_FULL - 1);

    // Sequence state, interval counter, element and sub-cycle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sub    <= '0;
            elem   <= '0;
            mode_q <= MODE_OUT1;
            bin_q  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st     <= ST_LEAD;
                    cnt    <= '0;
                    mode_q <= mode_in;
                    bin_q  <= bin_in;
                end
                ST_LEAD: if (cnt == CW'(GAP_CYC - 1)) begin
                    st  <= ST_XFER;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                ST_XFER: if (cnt == CW'(XFER_CYC - 1)) begin
                    st  <= ST_TRAIL;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                ST_TRAIL: if (cnt == CW'(GAP_CYC - 1)) begin
                    st   <= ST_SHIFT;
                    cnt  <= '0;
                    sub  <= '0;
                    elem <= '0;
                end else cnt <= cnt + 1'b1;
                ST_SHIFT: if (sub == SW'(ELEM_CYC - 1)) begin
                    sub <= '0;
                    if (elem == last_idx) st <= ST_IDLE;
                    else elem <= elem + 1'b1;
                end else sub <= sub + 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Element class from its index within the line.
    always_comb begin
        if (st != ST_SHIFT)                         tag = TAG_NONE;
        else if (elem < EW'(PRE))                   tag = TAG_PRESCAN;
        else if (elem < EW'(PRE + ISO_A))           tag = TAG_ISOL;
        else if (elem < EW'(PRE + ISO_A + DARK))    tag = TAG_DARK;
        else if (elem < EW'(HEAD))                  tag = TAG_ISOL;
        else                                        tag = TAG_PIXEL;
    end

    // Status decodes for the phase generator and the ports.
    assign shifting = (st == ST_SHIFT);
    assign xfer     = (st == ST_XFER);
    assign busy     = (st != ST_IDLE);
    assign elem_odd = elem[0];

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(mode_q) && $stable(bin_q)));

    // R2
    xfer_after_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && $past(st) != ST_XFER) |-> $past(st) == ST_LEAD);

endmodule

// File: rtl/ccdl_phase_gen.sv
// Per-element waveforms: L1 in the first half, L2 in the second half,
// reset gate in sub-cycle 0 and strobe in sub-cycle 2 of selected elements.
// Assumes ELEM_CYC >= 4 so that the strobe slot exists.
module ccdl_phase_gen #(
    parameter int ELEM_CYC = 4
) (
    input  logic                        shifting,
    input  logic [$clog2(ELEM_CYC)-1:0] sub,
    input  logic                        elem_odd,
    input  logic                        bin_q,
    output logic                        ph_l1,
    output logic                        ph_l2,
    output logic                        rst_g,
    output logic                        strb
);
    localparam int SW   = $clog2(ELEM_CYC);
    localparam int HALF = ELEM_CYC / 2;

    logic active_el;

    // Element gets a reset/sample unless binning skips odd elements.
    assign active_el = shifting && !(bin_q && elem_odd);

    // Phase and pulse decode from the sub-cycle position.
    always_comb begin
        ph_l1 = shifting && (sub < SW'(HALF));
        ph_l2 = shifting && (sub >= SW'(HALF));
        rst_g = active_el && (sub == '0);
        strb  = active_el && (sub == SW'(2));
    end

endmodule

// File: rtl/ccdl_router.sv
// Routes the two register clock phases onto six electrodes per port mode.
// Assumes the mode is held stable for the whole line.
module ccdl_router
    import ccdl_pkg::*;
(
    input  logic [1:0]      mode_q,
    input  logic            ph_l1,
    input  logic            ph_l2,
    output logic [EL_N-1:0] el
);
    logic [EL_N-1:0] sel_l1;

    // Phase selection table for the captured mode.
    assign sel_l1 = l1_map(mode_q);

    for (genvar i = 0; i < EL_N; i++) begin : g_el
        assign el[i] = sel_l1[i] ? ph_l1 : ph_l2;
    end

endmodule

// File: rtl/ccdl_line_seq.sv
// Top of the serial register line sequencer: control, phase generation and
// electrode routing. All outputs decode registered state only.
// Assumes one line per request; requests during a line are dropped.
module ccdl_line_seq
    import ccdl_pkg::*;
#(
    parameter int GAP_CYC  = 5,
    parameter int XFER_CYC = 8,
    parameter int ELEM_CYC = 4,
    parameter int PRE      = 12,
    parameter int ISO_A    = 1,
    parameter int DARK     = 16,
    parameter int ISO_B    = 5,
    parameter int PIX      = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic [1:0] port_mode,
    input  logic       bin_en,
    output logic       xfer_gate,
    output logic [5:0] reg_el,
    output logic       reset_gate,
    output logic       sample_stb,
    output logic [2:0] elem_tag,
    output logic       busy
);
    localparam int SW = $clog2(ELEM_CYC);

    logic          shifting, elem_odd, bin_q, ph_l1, ph_l2;
    logic [SW-1:0] sub;
    logic [1:0]    mode_q;
    tag_t          tag;

    ccdl_line_ctrl #(
        .GAP_CYC(GAP_CYC), .XFER_CYC(XFER_CYC), .ELEM_CYC(ELEM_CYC),
        .PRE(PRE), .ISO_A(ISO_A), .DARK(DARK), .ISO_B(ISO_B), .PIX(PIX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(line_start), .mode_in(port_mode),
        .bin_in(bin_en), .shifting(shifting), .xfer(xfer_gate), .busy(busy),
        .sub(sub), .elem_odd(elem_odd), .mode_q(mode_q), .bin_q(bin_q), .tag(tag)
    );

    ccdl_phase_gen #(.ELEM_CYC(ELEM_CYC)) u_phase (
        .shifting(shifting), .sub(sub), .elem_odd(elem_odd), .bin_q(bin_q),
        .ph_l1(ph_l1), .ph_l2(ph_l2), .rst_g(reset_gate), .strb(sample_stb)
    );

    ccdl_router u_route (
        .mode_q(mode_q), .ph_l1(ph_l1), .ph_l2(ph_l2), .el(reg_el)
    );

    assign elem_tag = tag;

    // R8
    strobe_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(reset_gate, 2));

    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_el[0] && reg_el[1]));

    // R5 R6 R7
    three_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_el != '0) |-> ($countones(reg_el) == 3));

    // R2
    xfer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_gate |-> (reg_el == '0 && !reset_gate));

    // R9
    unbinned_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reg_el[0]) && !bin_q) |-> reset_gate);

endmodule

// File: tb/ccdl_line_seq_test.sv
// Scoreboard bench: the driver queues one expected item per element, the
// monitor pops and compares at every L1 rising edge.
module ccdl_line_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic [1:0] port_mode = 2'd0;
    logic       bin_en = 1'b0;
    logic       xfer_gate, reset_gate, sample_stb, busy;
    logic [5:0] reg_el;
    logic [2:0] elem_tag;

    always #10 clk = ~clk;

    ccdl_line_seq uut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .port_mode(port_mode),
        .bin_en(bin_en), .xfer_gate(xfer_gate), .reg_el(reg_el),
        .reset_gate(reset_gate), .sample_stb(sample_stb), .elem_tag(elem_tag),
        .busy(busy)
    );

    typedef struct {
        int         idx;
        logic [2:0] tag;
        logic       rst;
        logic [5:0] m1;
        logic [5:0] m2;
        string      rq_map;
        string      rq_rst;
    } item_t;

    item_t expq[$];
    item_t cur;
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int lead_n, xfer_n, trail_n, xfer_pulses, elems, strobes, resets;
    int both_hi, idle_bad, strb_bad, l1_cyc, l2_cyc;
    int tag_cnt[5];
    logic prev_l1, prev_l2, prev_x, rst_d1, rst_d2, in_shift;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [5:0] mask_l1(input logic [1:0] m);
        case (m)
            2'd1:    return 6'b101001;
            2'd2:    return 6'b100101;
            default: return 6'b010101;
        endcase
    endfunction

    function automatic logic [2:0] tag_of(input int i);
        if (i < 12) return 3'd1;
        if (i < 13) return 3'd2;
        if (i < 29) return 3'd3;
        if (i < 34) return 3'd2;
        return 3'd4;
    endfunction

    task automatic clear_stats();
        lead_n = 0; xfer_n = 0; trail_n = 0; xfer_pulses = 0; elems = 0;
        strobes = 0; resets = 0; both_hi = 0; idle_bad = 0; strb_bad = 0;
        l1_cyc = 0; l2_cyc = 0;
        for (int k = 0; k < 5; k++) tag_cnt[k] = 0;
        prev_l1 = 0; prev_l2 = 0; prev_x = 0; rst_d1 = 0; rst_d2 = 0; in_shift = 0;
    endtask

    // Monitor: samples between edges and compares against queued items.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (xfer_gate && !prev_x) xfer_pulses++;
            if (xfer_gate) xfer_n++;
            else if (busy && xfer_pulses == 0) lead_n++;
            else if (busy && !in_shift && reg_el == 6'd0) trail_n++;
            if (reg_el[0] && !prev_l1) begin
                in_shift = 1;
                elems++;
                if (expq.size() == 0) check(0, "R3", "unexpected element", elems, 0);
                else begin
                    cur = expq.pop_front();
                    if (elem_tag < 5) tag_cnt[elem_tag]++;
                    check(elem_tag == cur.tag, "R3", $sformatf("tag at element %0d", cur.idx),
                          elem_tag, cur.tag);
                    check(reset_gate == cur.rst, cur.rq_rst,
                          $sformatf("reset at element %0d", cur.idx), reset_gate, cur.rst);
                    check(reg_el == cur.m1, cur.rq_map,
                          $sformatf("L1 electrodes at element %0d", cur.idx), reg_el, cur.m1);
                end
            end
            if (reg_el[1] && !prev_l2 && in_shift)
                check(reg_el == cur.m2, cur.rq_map,
                      $sformatf("L2 electrodes at element %0d", cur.idx), reg_el, cur.m2);
            if (reg_el[0]) l1_cyc++;
            if (reg_el[1]) l2_cyc++;
            if (reg_el[0] && reg_el[1]) both_hi++;
            if (!busy && (reg_el != 0 || reset_gate || sample_stb || xfer_gate || elem_tag != 0))
                idle_bad++;
            if (reset_gate) resets++;
            if (sample_stb) begin
                strobes++;
                if (!rst_d2) strb_bad++;
            end
            rst_d2 = rst_d1; rst_d1 = reset_gate;
            prev_l1 = reg_el[0]; prev_l2 = reg_el[1]; prev_x = xfer_gate;
        end
    end

    // Driver: queues the expected line, starts it, then checks line totals.
    task automatic run_line(input logic [1:0] m, input logic b, input bit disturb,
                            input string rq_map);
        int nel;
        int pix;
        int guard;
        int exp_pulses;
        item_t it;
        pix = (m == 2'd2) ? 512 : 1024;
        nel = 34 + pix;
        for (int i = 0; i < nel; i++) begin
            it.idx = i;
            it.tag = tag_of(i);
            it.rst = !b || (i % 2 == 0);
            it.m1 = mask_l1(m);
            it.m2 = ~mask_l1(m);
            it.rq_map = rq_map;
            it.rq_rst = b ? "R9" : "R8";
            expq.push_back(it);
        end
        @(negedge clk); #1;
        clear_stats();
        port_mode = m; bin_en = b; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        if (disturb) begin
            repeat (400) @(negedge clk);
            port_mode = 2'd2; bin_en = ~b; line_start = 1'b1;   // R10 stimulus
            @(negedge clk);
            line_start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 10000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        #1;
        exp_pulses = b ? (nel + 1) / 2 : nel;
        check(lead_n == 5, "R2", "quiet cycles before transfer", lead_n, 5);
        check(xfer_n == 8, "R2", "transfer gate width", xfer_n, 8);
        check(trail_n == 5, "R2", "quiet cycles after transfer", trail_n, 5);
        check(xfer_pulses == 1, "R10", "transfer pulses per line", xfer_pulses, 1);
        check(elems == nel, "R3", "element count", elems, nel);
        check(expq.size() == 0, "R3", "elements missing", expq.size(), 0);
        check(tag_cnt[1] == 12, "R3", "prescan tags", tag_cnt[1], 12);
        check(tag_cnt[2] == 6, "R3", "isolation tags", tag_cnt[2], 6);
        check(tag_cnt[3] == 16, "R3", "dark tags", tag_cnt[3], 16);
        check(tag_cnt[4] == pix, "R3", "pixel tags", tag_cnt[4], pix);
        check(both_hi == 0, "R4", "cycles with both phases high", both_hi, 0);
        check(l1_cyc == 2 * nel, "R4", "L1 high cycles", l1_cyc, 2 * nel);
        check(l2_cyc == 2 * nel, "R4", "L2 high cycles", l2_cyc, 2 * nel);
        check(idle_bad == 0, "R4", "activity while idle", idle_bad, 0);
        check(resets == exp_pulses, b ? "R9" : "R8", "reset pulses", resets, exp_pulses);
        check(strobes == exp_pulses, b ? "R9" : "R8", "strobes", strobes, exp_pulses);
        check(strb_bad == 0, "R8", "strobes not two cycles after reset", strb_bad, 0);
        expq.delete();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Test sequence.
    initial begin
        clear_stats();
        repeat (3) @(negedge clk);
        check(!busy && !xfer_gate && !reset_gate && !sample_stb, "R1",
              "control outputs in reset", {busy, xfer_gate, reset_gate, sample_stb}, 0);
        check(reg_el == 6'd0 && elem_tag == 3'd0, "R1", "electrodes and tag in reset",
              {reg_el, elem_tag}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!busy && reg_el == 6'd0 && elem_tag == 3'd0, "R1", "idle after reset",
              {busy, reg_el, elem_tag}, 0);

        run_line(2'd0, 1'b0, 1'b1, "R5");   // with a mid-line disturbance, R10
        run_line(2'd1, 1'b0, 1'b0, "R6");
        run_line(2'd2, 1'b1, 1'b0, "R7");
        run_line(2'd3, 1'b0, 1'b0, "R5");
        run_line(2'd0, 1'b1, 1'b0, "R5");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule